// File: doc/BRIEF.md
# I2C hung-bus recovery sequencer

This block frees an I2C bus that a peer device left stuck when it lost its place partway through a transfer. A stuck peer typically holds the data line low while it waits for clock edges that never arrive. On a start request the block looks at the synchronised data line. If the line is low, it clocks the bus by pulling SCL low for a fixed time and then releasing it for the same time. After each such pulse it checks both lines. The loop stops once both lines read high, or gives up once a pulse limit is reached.

When recovery succeeds, or when the data line was never stuck, the block sends a fixed burst of START conditions. These reset the state machine of every peer on the bus. The block then leaves both lines undriven and reports the result with a one-cycle done strobe and a held fail flag.

Both lines are driven open-drain: an asserted pull output drags the line low, and a deasserted one releases it. The line levels come back in through a two-flop synchroniser. Every wait is a whole number of system clock cycles, set by parameters. Defaults give 62 µs per pulse phase and a 5 µs half-period (100 kHz) at 250 MHz.

Top module: `i2c_hang_recover`

## Requirements
- R1: After reset, `scl_pull_o`, `sda_pull_o`, `busy_o`, `done_o` and `fail_o` are all 0.
- R2: If the synchronised SDA reads high one cycle after the start request is accepted, no clock pulse is issued and the START burst begins at once. The run then ends with `fail_o`=0.
- R3: If SDA reads low at that point, each recovery pulse holds `scl_pull_o`=1 for ABORT_CYC cycles. It then holds `scl_pull_o`=0 for ABORT_CYC cycles, followed by one sampling cycle.
- R4: In the sampling cycle the synchronised SCL and SDA are both checked. The first pulse after which both read high ends the loop and starts the START burst.
- R5: At most MAX_PULSES (16) pulses are issued. If both lines are not high after the last one, the run ends with `fail_o`=1 and `sda_pull_o` is never asserted.
- R6: The START burst is START_REPS (5) back-to-back sequences. Each sequence has four steps of HALF_CYC cycles, applied in this order: release SDA, release SCL, pull SDA low, pull SCL low.
- R7: A run ends with `done_o`=1 for exactly one cycle. In that same cycle `busy_o`=0 and both pull outputs are 0.
- R8: `fail_o` changes only when a start request is accepted, where it clears to 0, or when a run ends, where it takes the result.
- R9: `start_i` is accepted only while `busy_o`=0. A request made during a run has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a recovery run |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| fail_o | output | 1 | Result of the last run, held |

## Verification
Every output is due at a fixed cycle after the accepting edge:
- `busy_o` rises at that edge, and the SDA decision falls one cycle later.
- Each recovery pulse takes 2·ABORT_CYC+1 cycles, sampling cycle included.
- The START burst takes 4·HALF_CYC·START_REPS cycles, and `done_o` rises on its last edge.

The bench has a behavioural model that steps through these counts with edge waits, driven by a simulated stuck peer. The peer releases SDA, and separately a jam on SCL, after a chosen number of SCL releases. The model and the design are compared at every falling clock edge, half a cycle away from the edges where either can change. After each run the bench also counts the rising edges seen on both pull outputs against the expected pulse and START totals.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PULL_LO,
    ST_REL_HI,
    ST_PROBE,
    ST_SDA_UP,
    ST_SCL_UP,
    ST_SDA_DN,
    ST_SCL_DN
  } rcv_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
  parameter int unsigned       WIDTH   = 2,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rcv_timer.sv
module i2c_rcv_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_rcv_tally.sv
module i2c_rcv_tally #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/i2c_hang_recover.sv
module i2c_hang_recover
  import i2c_rcv_pkg::*;
#(
  parameter int unsigned ABORT_CYC   = 15500,
  parameter int unsigned HALF_CYC    = 1250,
  parameter int unsigned MAX_PULSES  = 16,
  parameter int unsigned START_REPS  = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned TMR_MAX = max_u(max_u(ABORT_CYC, HALF_CYC), 2);
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned PLS_W   = $clog2(MAX_PULSES + 1);
  localparam int unsigned REP_W   = $clog2(START_REPS + 1);
  localparam logic [TMR_W-1:0] ABORT_LD = TMR_W'(ABORT_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_LD  = TMR_W'(HALF_CYC - 1);
  localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(MAX_PULSES);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(START_REPS - 1);

  rcv_state_e state_q, state_d;
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic       pls_clr, pls_inc, rep_clr, rep_inc;
  logic [PLS_W-1:0] pls_cnt;
  logic [REP_W-1:0] rep_cnt;
  logic       scl_q, scl_d, sda_q, sda_d, done_q, done_d, fail_q, fail_d;

  i2c_rcv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_rcv_timer #(.W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  i2c_rcv_tally #(.W(PLS_W)) u_pulses (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pls_clr), .inc_i(pls_inc), .cnt_o(pls_cnt)
  );

  i2c_rcv_tally #(.W(REP_W)) u_reps (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rep_clr), .inc_i(rep_inc), .cnt_o(rep_cnt)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    pls_clr  = 1'b0;
    pls_inc  = 1'b0;
    rep_clr  = 1'b0;
    rep_inc  = 1'b0;
    scl_d    = scl_q;
    sda_d    = sda_q;
    done_d   = 1'b0;
    fail_d   = fail_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CHECK;
        fail_d  = 1'b0;
        pls_clr = 1'b1;
      end
      ST_CHECK: begin
        tmr_load = 1'b1;
        if (!sda_s) begin
          state_d = ST_PULL_LO;
          scl_d   = 1'b1;
          tmr_val = ABORT_LD;
        end else begin
          state_d = ST_SDA_UP;
          sda_d   = 1'b0;
          rep_clr = 1'b1;
        end
      end
      ST_PULL_LO: if (tmr_zero) begin
        state_d  = ST_REL_HI;
        scl_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = ABORT_LD;
        pls_inc  = 1'b1;
      end
      ST_REL_HI: if (tmr_zero) state_d = ST_PROBE;
      ST_PROBE: begin
        if (scl_s && sda_s) begin
          state_d  = ST_SDA_UP;
          sda_d    = 1'b0;
          tmr_load = 1'b1;
          rep_clr  = 1'b1;
        end else if (pls_cnt == PLS_LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          state_d  = ST_PULL_LO;
          scl_d    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = ABORT_LD;
        end
      end
      ST_SDA_UP: if (tmr_zero) begin
        state_d  = ST_SCL_UP;
        scl_d    = 1'b0;
        tmr_load = 1'b1;
      end
      ST_SCL_UP: if (tmr_zero) begin
        state_d  = ST_SDA_DN;
        sda_d    = 1'b1;
        tmr_load = 1'b1;
      end
      ST_SDA_DN: if (tmr_zero) begin
        state_d  = ST_SCL_DN;
        scl_d    = 1'b1;
        tmr_load = 1'b1;
      end
      ST_SCL_DN: if (tmr_zero) begin
        rep_inc = 1'b1;
        if (rep_cnt == REP_LAST) begin
          state_d = ST_IDLE;
          scl_d   = 1'b0;
          sda_d   = 1'b0;
          done_d  = 1'b1;
        end else begin
          state_d  = ST_SDA_UP;
          sda_d    = 1'b0;
          tmr_load = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        scl_d   = 1'b0;
        sda_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign scl_pull_o = scl_q;
  assign sda_pull_o = sda_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/i2c_hang_recover_chk.sv
module i2c_hang_recover_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_lines_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scl_pull_o && !sda_pull_o && !busy_o));

  a_r5_fail_no_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !sda_pull_o);

  a_r8_fail_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && !busy_o) |=> (done_o || $stable(fail_o)));

  a_r9_pulls_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_pull_o || sda_pull_o) |-> busy_o);
endmodule

bind i2c_hang_recover i2c_hang_recover_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .scl_pull_o(scl_pull_o),
  .sda_pull_o(sda_pull_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o)
);

// File: tb/i2c_hang_recover_tb.sv
module i2c_hang_recover_tb;
  localparam int A    = 5;
  localparam int H    = 3;
  localparam int MAXP = 16;
  localparam int REPS = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic scl_line, sda_line;
  logic scl_pull, sda_pull, busy, done, fail;

  always #2 clk = ~clk;

  // stuck peer: SDA held until k_sda SCL releases, SCL jammed until j_scl releases
  int rel_cnt = 0, rel_base = 0, k_sda = 0, j_scl = 0;
  int scl_rise = 0, sda_rise = 0;
  logic scl_prev = 1'b0, sda_prev = 1'b0;

  assign sda_line = !(sda_pull || ((rel_cnt - rel_base) < k_sda));
  assign scl_line = !(scl_pull || ((rel_cnt - rel_base) < j_scl));

  i2c_hang_recover #(.ABORT_CYC(A), .HALF_CYC(H), .MAX_PULSES(MAXP), .START_REPS(REPS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  always @(negedge clk) begin
    if (scl_prev && !scl_pull) rel_cnt <= rel_cnt + 1;
    if (!scl_prev && scl_pull) scl_rise <= scl_rise + 1;
    if (!sda_prev && sda_pull) sda_rise <= sda_rise + 1;
    scl_prev <= scl_pull;
    sda_prev <= sda_pull;
  end

  // behavioural reference model
  logic exp_scl = 0, exp_sda = 0, exp_busy = 0, exp_done = 0, exp_fail = 0;

  task automatic model_run();
    int ok;
    exp_busy = 1; exp_fail = 0;
    @(posedge clk);
    if (k_sda != 0) begin
      ok = 0;
      for (int p = 1; p <= MAXP; p++) begin
        exp_scl = 1; repeat (A) @(posedge clk);
        exp_scl = 0; repeat (A) @(posedge clk);
        @(posedge clk);
        if (p >= k_sda && p >= j_scl) begin ok = 1; break; end
      end
      if (ok == 0) begin
        exp_done = 1; exp_fail = 1; exp_busy = 0;
        return;
      end
    end
    for (int r = 0; r < REPS; r++) begin
      exp_sda = 0; repeat (H) @(posedge clk);
      exp_scl = 0; repeat (H) @(posedge clk);
      exp_sda = 1; repeat (H) @(posedge clk);
      exp_scl = 1; repeat (H) @(posedge clk);
    end
    exp_scl = 0; exp_sda = 0; exp_done = 1; exp_busy = 0;
  endtask

  initial begin
    @(posedge rst_ni);
    forever begin
      @(posedge clk);
      exp_done = 0;
      if (start_i) model_run();
    end
  end

  string cur_tag = "R1";
  int cyc_checks = 0, cyc_errs = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc_checks++;
      if ({scl_pull, sda_pull, busy, done, fail} !== {exp_scl, exp_sda, exp_busy, exp_done, exp_fail}) begin
        cyc_errs++;
        $display("FAIL %s t=%0t actual scl/sda/busy/done/fail=%b%b%b%b%b expected=%b%b%b%b%b",
                 cur_tag, $time, scl_pull, sda_pull, busy, done, fail,
                 exp_scl, exp_sda, exp_busy, exp_done, exp_fail);
      end
    end
  end

  int checks = 0, errors = 0;
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input int k, input int j, input int inject,
                          input int exp_f, input int exp_scl_n, input int exp_sda_n);
    int s0, d0;
    @(negedge clk);
    cur_tag = tag;
    rel_base = rel_cnt; k_sda = k; j_scl = j;
    repeat (4) @(negedge clk);
    s0 = scl_rise; d0 = sda_rise;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (inject != 0) begin
      repeat (inject) @(negedge clk);
      start_i = 1'b1;           // R9: request while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < 5000 && !done; w++) @(negedge clk);
    check({tag, " done seen"}, done, 1);
    check({tag, " fail result"}, fail, exp_f);
    @(negedge clk);
    check({tag, " scl pulses"}, scl_rise - s0, exp_scl_n);
    check({tag, " sda pulls"}, sda_rise - d0, exp_sda_n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 scl_pull", scl_pull, 0);
    check("R1 sda_pull", sda_pull, 0);
    check("R1 busy", busy, 0);
    check("R1 done/fail", {30'd0, done, fail}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    run_case("R2_R6_R7 free bus", 0, 0, 0, 0, REPS, REPS);
    run_case("R3_R4 sda stuck 3", 3, 0, 0, 0, 3 + REPS, REPS);
    run_case("R4 scl jam 6", 2, 6, 0, 0, 6 + REPS, REPS);
    run_case("R4_R5 limit exact 16", 16, 0, 0, 0, 16 + REPS, REPS);
    run_case("R5 never frees", 40, 0, 0, 1, MAXP, 0);
    repeat (12) @(negedge clk);
    cur_tag = "R8 held";
    check("R8 fail held while idle", fail, 1);
    check("R9 idle after run", busy, 0);
    run_case("R5 limit 17", 17, 0, 0, 1, MAXP, 0);
    run_case("R8_R9 start during run", 4, 0, 20, 0, 4 + REPS, REPS);
    repeat (8) @(negedge clk);
    check("R9 no second run", busy, 0);
    check("R9 lines free", {31'd0, scl_pull | sda_pull}, 0);
    check("R8 fail cleared", fail, 0);

    $display("Result: errors=%0d of %0d checks", errors + cyc_errs, checks + cyc_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + cyc_errs + 1, checks + cyc_checks + 1);
    $finish;
  end
endmodule